// File: doc/BRIEF.md
# SDRAM Refresh Interval Scheduler

This block decides when a DDR2 SDRAM controller must refresh its memory. A programmed rate value sets the length of an interval timer; each time the timer runs out, one refresh becomes owed. Owed refreshes go into a small saturating backlog. While the controller still has read or write traffic pending, refreshes wait. They are issued when the controller goes idle, or forcibly once the backlog is full. Every refresh is preceded by a precharge-all request, so that all banks are closed when the refresh command reaches the device.

The block also handles entry to and exit from self-refresh, which must happen before the controller clocks are gated off. The command sequencer downstream answers each request with a one-cycle grant. The block never drives DRAM pins itself.

Top module: `refresh_sched`

## Requirements
- R1: With a nonzero rate value N held from reset release, one refresh becomes owed every N+1 cycles. The first one is owed N+2 cycles after the first clock edge with reset released.
- R2: The owed count saturates at BACKLOG_MAX (default 8). Once it is full, a precharge-all is requested even though idle_i is 0.
- R3: A refresh request is raised only in the cycle after a precharge-all grant that was given for a refresh, never directly from the idle state.
- R4: Each request output stays high until its grant input is sampled high, and at most one of the four request outputs is high at any time.
- R5: While idle_i is 0 and the backlog is below full, no refresh is started. While idle_i is 1 and the backlog is nonzero, precharge-all/refresh pairs repeat until the backlog is empty. Each refresh grant removes one owed refresh.
- R6: A rate value of 0 stops and clears the interval timer and blocks any new precharge-all for refresh. The backlog keeps its value. A later nonzero rate reloads the timer from that value.
- R7: sr_req_i = 1 takes priority over owed refreshes. It leads to a precharge-all, then to a self-refresh entry request, and after that grant in_sr_o goes to 1.
- R8: When sr_req_i falls during self-refresh, an exit request is raised. After its grant comes a precharge-all, then one refresh, whatever the rate value. At that refresh grant the backlog is cleared.
- R9: During and right after reset, all request outputs and in_sr_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_i | input | RATE_W | Refresh interval value; 0 disables interval refresh |
| idle_i | input | 1 | 1 when the controller has no read/write traffic pending |
| sr_req_i | input | 1 | Self-refresh control bit; 1 requests self-refresh |
| pre_gnt_i | input | 1 | Grant for the precharge-all request |
| ref_gnt_i | input | 1 | Grant for the refresh request |
| sre_gnt_i | input | 1 | Grant for the self-refresh entry request |
| srx_gnt_i | input | 1 | Grant for the self-refresh exit request |
| pre_req_o | output | 1 | Precharge-all request |
| ref_req_o | output | 1 | Auto-refresh request |
| sre_req_o | output | 1 | Self-refresh entry request |
| srx_req_o | output | 1 | Self-refresh exit request |
| in_sr_o | output | 1 | Device is in self-refresh; clocks may be stopped |

## Verification
The bench measures the exact cycle of the first forced precharge-all for random rate values while traffic stays pending. An off-by-one in the timer reload or in the saturation point moves that edge. It holds off a grant long enough to overflow a non-saturating backlog, then counts the refreshes drained: a backlog that wraps or keeps growing yields a number other than eight. It drives a zero rate with owed refreshes pending, where a design that ignores the disable still issues requests. It also checks that a self-refresh exit is followed by one refresh and then silence, whereas a design that keeps the stale backlog goes on draining it.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_REF,
        ST_SRE,
        ST_SELF,
        ST_SRX
    } seq_state_e;

    typedef enum logic [1:0] {
        GOAL_REF,
        GOAL_SR,
        GOAL_EXIT
    } goal_e;

endpackage

// File: rtl/refresh_interval.sv
module refresh_interval #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);

    typedef struct packed {
        logic              armed;
        logic [RATE_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic tick_d;

    always_comb begin
        tmr_d  = tmr_q;
        tick_d = 1'b0;
        if (rate_i == '0) begin
            tmr_d.armed = 1'b0;
            tmr_d.cnt   = '0;
        end else if (!tmr_q.armed) begin
            tmr_d.armed = 1'b1;
            tmr_d.cnt   = rate_i;
        end else if (tmr_q.cnt == '0) begin
            tick_d    = 1'b1;
            tmr_d.cnt = rate_i;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tick_o = tick_d;

endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
    parameter int BACKLOG_MAX = 8,
    localparam int CNT_W = $clog2(BACKLOG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(BACKLOG_MAX);

    logic [CNT_W-1:0] count_d, count_q;
    logic             full_w, empty_w, inc_eff, dec_eff;

    always_comb begin
        full_w  = (count_q == FULL_VAL);
        empty_w = (count_q == '0);
        dec_eff = dec_i && !empty_w;
        inc_eff = inc_i && (!full_w || dec_eff);
        count_d = count_q;
        if (clr_i) begin
            count_d = '0;
        end else begin
            case ({inc_eff, dec_eff})
                2'b10:   count_d = count_q + 1'b1;
                2'b01:   count_d = count_q - 1'b1;
                default: count_d = count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;

endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
    import refresh_pkg::*;
#(
    parameter int BACKLOG_MAX = 8,
    localparam int CNT_W = $clog2(BACKLOG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_req_i,
    input  logic             idle_i,
    input  logic             rate_zero_i,
    input  logic [CNT_W-1:0] owed_i,
    input  logic             pre_gnt_i,
    input  logic             ref_gnt_i,
    input  logic             sre_gnt_i,
    input  logic             srx_gnt_i,
    output logic             pre_req_o,
    output logic             ref_req_o,
    output logic             sre_req_o,
    output logic             srx_req_o,
    output logic             in_sr_o,
    output logic             dec_o,
    output logic             clr_o
);

    localparam logic [CNT_W-1:0] FULL_VAL = CNT_W'(BACKLOG_MAX);

    typedef struct packed {
        seq_state_e st;
        goal_e      goal;
    } seq_t;

    seq_t seq_d, seq_q;
    logic owed_full, owed_any;

    always_comb begin
        seq_d     = seq_q;
        dec_o     = 1'b0;
        clr_o     = 1'b0;
        owed_full = (owed_i == FULL_VAL);
        owed_any  = (owed_i != '0);
        case (seq_q.st)
            ST_IDLE: begin
                if (sr_req_i) begin
                    seq_d.st   = ST_PRE;
                    seq_d.goal = GOAL_SR;
                end else if (!rate_zero_i && (owed_full || (owed_any && idle_i))) begin
                    seq_d.st   = ST_PRE;
                    seq_d.goal = GOAL_REF;
                end
            end
            ST_PRE: begin
                if (pre_gnt_i) seq_d.st = (seq_q.goal == GOAL_SR) ? ST_SRE : ST_REF;
            end
            ST_REF: begin
                if (ref_gnt_i) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.goal = GOAL_REF;
                    if (seq_q.goal == GOAL_EXIT) clr_o = 1'b1;
                    else                         dec_o = 1'b1;
                end
            end
            ST_SRE: begin
                if (sre_gnt_i) seq_d.st = ST_SELF;
            end
            ST_SELF: begin
                if (!sr_req_i) seq_d.st = ST_SRX;
            end
            ST_SRX: begin
                if (srx_gnt_i) begin
                    seq_d.st   = ST_PRE;
                    seq_d.goal = GOAL_EXIT;
                end
            end
            default: begin
                seq_d.st   = ST_IDLE;
                seq_d.goal = GOAL_REF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.goal <= GOAL_REF;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pre_req_o = (seq_q.st == ST_PRE);
    assign ref_req_o = (seq_q.st == ST_REF);
    assign sre_req_o = (seq_q.st == ST_SRE);
    assign srx_req_o = (seq_q.st == ST_SRX);
    assign in_sr_o   = (seq_q.st == ST_SELF);

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int RATE_W      = 16,
    parameter int BACKLOG_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              idle_i,
    input  logic              sr_req_i,
    input  logic              pre_gnt_i,
    input  logic              ref_gnt_i,
    input  logic              sre_gnt_i,
    input  logic              srx_gnt_i,
    output logic              pre_req_o,
    output logic              ref_req_o,
    output logic              sre_req_o,
    output logic              srx_req_o,
    output logic              in_sr_o
);

    localparam int CNT_W = $clog2(BACKLOG_MAX + 1);

    logic             tick_w;
    logic             dec_w;
    logic             clr_w;
    logic             rate_zero_w;
    logic [CNT_W-1:0] owed_cnt;

    assign rate_zero_w = (rate_i == '0);

    refresh_interval #(
        .RATE_W (RATE_W)
    ) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate_i (rate_i),
        .tick_o (tick_w)
    );

    refresh_backlog #(
        .BACKLOG_MAX (BACKLOG_MAX)
    ) u_backlog (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (tick_w),
        .dec_i   (dec_w),
        .clr_i   (clr_w),
        .count_o (owed_cnt)
    );

    refresh_seq #(
        .BACKLOG_MAX (BACKLOG_MAX)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_req_i    (sr_req_i),
        .idle_i      (idle_i),
        .rate_zero_i (rate_zero_w),
        .owed_i      (owed_cnt),
        .pre_gnt_i   (pre_gnt_i),
        .ref_gnt_i   (ref_gnt_i),
        .sre_gnt_i   (sre_gnt_i),
        .srx_gnt_i   (srx_gnt_i),
        .pre_req_o   (pre_req_o),
        .ref_req_o   (ref_req_o),
        .sre_req_o   (sre_req_o),
        .srx_req_o   (srx_req_o),
        .in_sr_o     (in_sr_o),
        .dec_o       (dec_w),
        .clr_o       (clr_w)
    );

endmodule

// File: rtl/refresh_sched_checker.sv
module refresh_sched_checker #(
    parameter int RATE_W      = 16,
    parameter int BACKLOG_MAX = 8,
    localparam int CNT_W = $clog2(BACKLOG_MAX + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [RATE_W-1:0] rate_i,
    input logic              sr_req_i,
    input logic              pre_gnt_i,
    input logic              ref_gnt_i,
    input logic              sre_gnt_i,
    input logic              srx_gnt_i,
    input logic              pre_req_o,
    input logic              ref_req_o,
    input logic              sre_req_o,
    input logic              srx_req_o,
    input logic              in_sr_o,
    input logic [CNT_W-1:0]  owed
);

    // R4: never two requests at once
    a_r4_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_req_o, ref_req_o, sre_req_o, srx_req_o}));

    // R4: precharge-all request held until granted
    a_r4_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_req_o && !pre_gnt_i) |=> pre_req_o);

    // R4: refresh request held until granted
    a_r4_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req_o && !ref_gnt_i) |=> ref_req_o);

    // R2: backlog never exceeds its cap
    a_r2_backlog_cap: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= CNT_W'(BACKLOG_MAX));

    // R3: refresh only right after a granted precharge-all
    a_r3_ref_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_req_o) |-> $past(pre_req_o && pre_gnt_i));

    // R7: self-refresh entry only right after a granted precharge-all
    a_r7_sre_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sre_req_o) |-> $past(pre_req_o && pre_gnt_i));

    // R7: self-refresh state follows an entry grant
    a_r7_in_sr_after_gnt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sr_o) |-> $past(sre_req_o && sre_gnt_i));

    // R6: a new precharge-all needs a nonzero rate, a self-refresh request or an exit
    a_r6_rate_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pre_req_o) |-> $past((rate_i != '0) || sr_req_i || srx_req_o));

    // R8: exit request only out of self-refresh with the control bit low
    a_r8_srx_from_sr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srx_req_o) |-> $past(in_sr_o && !sr_req_i));

endmodule

bind refresh_sched refresh_sched_checker #(
    .RATE_W      (RATE_W),
    .BACKLOG_MAX (BACKLOG_MAX)
) u_refresh_sched_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_i    (rate_i),
    .sr_req_i  (sr_req_i),
    .pre_gnt_i (pre_gnt_i),
    .ref_gnt_i (ref_gnt_i),
    .sre_gnt_i (sre_gnt_i),
    .srx_gnt_i (srx_gnt_i),
    .pre_req_o (pre_req_o),
    .ref_req_o (ref_req_o),
    .sre_req_o (sre_req_o),
    .srx_req_o (srx_req_o),
    .in_sr_o   (in_sr_o),
    .owed      (owed_cnt)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;

    localparam int RATE_W = 16;
    localparam int BMAX   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RATE_W-1:0] rate = '0;
    logic              idle = 1'b0;
    logic              sr_req = 1'b0;
    logic              pre_gnt = 1'b0, ref_gnt = 1'b0, sre_gnt = 1'b0, srx_gnt = 1'b0;
    logic              pre_req, ref_req, sre_req, srx_req, in_sr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    refresh_sched #(.RATE_W(RATE_W), .BACKLOG_MAX(BMAX)) u_refresh_sched (
        .clk(clk), .rst_n(rst_n), .rate_i(rate), .idle_i(idle), .sr_req_i(sr_req),
        .pre_gnt_i(pre_gnt), .ref_gnt_i(ref_gnt), .sre_gnt_i(sre_gnt), .srx_gnt_i(srx_gnt),
        .pre_req_o(pre_req), .ref_req_o(ref_req), .sre_req_o(sre_req),
        .srx_req_o(srx_req), .in_sr_o(in_sr)
    );

    // expected edge of the first forced precharge-all under pending traffic
    function automatic int forced_edge(input int n);
        return BMAX * (n + 1) + 2;
    endfunction

    // expected edge of the first opportunistic precharge-all while idle
    function automatic int idle_edge(input int n);
        return n + 3;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input int r, input logic idl);
        rst_n  = 1'b0;
        rate   = RATE_W'(r);
        idle   = idl;
        sr_req = 1'b0;
        {pre_gnt, ref_gnt, sre_gnt, srx_gnt} = '0;
        step(3);
        rst_n = 1'b1;
    endtask

    function automatic int reqs();
        return {28'd0, pre_req, ref_req, sre_req, srx_req};
    endfunction

    task automatic wait_pre(input int lim, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < lim; i++) begin
            if (pre_req) begin
                seen = 1'b1;
                break;
            end
            step(1);
        end
    endtask

    // serve one precharge-all + refresh pair; precharge-all already high
    task automatic serve_pair(input string tag);
        pre_gnt = 1'b1; step(1); pre_gnt = 1'b0;
        chk({tag, " ref after pre grant"}, reqs(), 4'b0100);
        ref_gnt = 1'b1; step(1); ref_gnt = 1'b0;
        chk({tag, " idle after ref grant"}, reqs(), 0);
    endtask

    task automatic drain(input string tag, output int n);
        bit seen;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            wait_pre(40, seen);
            if (!seen) break;
            serve_pair(tag);
            n++;
        end
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int n, e, cnt;
        bit quiet;
        seed = $urandom(32'd4242);

        // R9: reset state
        rst_n = 1'b0; step(2);
        chk("R9 requests in reset", reqs(), 0);
        chk("R9 in_sr in reset", int'(in_sr), 0);
        do_reset(5, 1'b0);
        step(1);
        chk("R9 requests after release", reqs(), 0);

        // R1 R2 R5: forced refresh timing under pending traffic, random rates
        for (int t = 0; t < 6; t++) begin
            n = 1 + int'($urandom % 24);
            do_reset(n, 1'b0);
            e = forced_edge(n);
            step(e - 1);
            chk("R5 no refresh before backlog full", int'(pre_req), 0);
            step(1);
            chk("R1 R2 forced pre at full backlog", int'(pre_req), 1);
            serve_pair("R3");
        end

        // R1 R5: opportunistic refresh while idle, random rates
        for (int t = 0; t < 4; t++) begin
            n = 1 + int'($urandom % 30);
            do_reset(n, 1'b1);
            e = idle_edge(n);
            step(e - 1);
            chk("R1 no pre before first tick", int'(pre_req), 0);
            step(1);
            chk("R5 idle pre after first tick", int'(pre_req), 1);
            step(3);
            chk("R4 pre held without grant", reqs(), 4'b1000);
            serve_pair("R3");
        end

        // R5: postponed backlog of 3 drains exactly while idle
        do_reset(80, 1'b0);
        step(250);
        chk("R5 busy backlog postponed", int'(pre_req), 0);
        idle = 1'b1;
        drain("R5", cnt);
        chk("R5 drained count", cnt, 3);

        // R2 R6: saturation and rate-zero disable
        do_reset(20, 1'b0);
        step(forced_edge(20));
        chk("R2 forced pre", int'(pre_req), 1);
        step(250);
        chk("R4 pre held long", int'(pre_req), 1);
        rate = '0;
        step(2);
        serve_pair("R2");
        idle = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 50; i++) begin
            if (pre_req) quiet = 1'b0;
            step(1);
        end
        chk("R6 rate zero blocks refresh", int'(quiet), 1);
        rate = 16'd1000;
        drain("R2", cnt);
        chk("R2 saturated backlog drained", cnt, BMAX - 1);

        // R7 R8: self-refresh entry and exit
        do_reset(10, 1'b0);
        step(36);
        sr_req = 1'b1;
        step(1);
        chk("R7 pre before self-refresh", reqs(), 4'b1000);
        pre_gnt = 1'b1; step(1); pre_gnt = 1'b0;
        chk("R7 entry request", reqs(), 4'b0010);
        step(2);
        chk("R4 entry request held", reqs(), 4'b0010);
        sre_gnt = 1'b1; step(1); sre_gnt = 1'b0;
        chk("R7 in self-refresh", int'(in_sr), 1);
        chk("R7 no requests in self-refresh", reqs(), 0);
        step(30);
        rate = 16'd1000;
        step(15);
        chk("R7 still in self-refresh", int'(in_sr), 1);
        chk("R7 still quiet", reqs(), 0);
        sr_req = 1'b0;
        step(1);
        chk("R8 exit request", reqs(), 4'b0001);
        srx_gnt = 1'b1; step(1); srx_gnt = 1'b0;
        chk("R8 pre after exit", reqs(), 4'b1000);
        chk("R8 in_sr low after exit", int'(in_sr), 0);
        serve_pair("R8");
        idle = 1'b1;
        quiet = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (pre_req) quiet = 1'b0;
            step(1);
        end
        chk("R8 backlog cleared on exit", int'(quiet), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule